// File: doc/BRIEF.md
# Power-of-Two Region Fitter

This block turns an arbitrary byte range, given as a start address and a length, into settings for a memory protection unit whose regions must be a power of two in size and aligned to that size. It picks an aligned region large enough to hold the range. It then divides that region into eight equal slices and works out which slices the range actually touches. Slices the range does not touch are marked disabled, so the protected area follows the range more closely than the bare region would.

A range that straddles an alignment boundary may not fit in one region under this rule. In that case the block cuts the range where the first region ends. The part before the cut goes into a descriptor at the given slot index, and the part after the cut goes into a second descriptor at the following index. The block reports how many slots it used and the first free slot after them. A zero length, or a range that runs past the top of the address space, is rejected with an error flag.

The computation is a two-stage pipeline. A start strobe is accepted on every clock, and each request gets a one-cycle done pulse exactly two cycles later. The block only produces descriptors; writing them into a register file is left to the surrounding logic.

Top module: `region_fitter`

## Requirements
- R1: A request strobed on `start_i` at a clock edge produces a one-cycle `done_o` pulse after the second following edge. `done_o` is low in every cycle without a matching request.
- R2: A request with `size_i` equal to zero completes with `err_o` high, `nreg_o` = 0, all descriptor fields zero with enables low, and `next_idx_o` equal to `idx_i`.
- R3: A request where `begin_i + size_i` exceeds 2^AW is rejected in the same way as in R2.
- R4: The region for a range [b, b+s) is found as follows. The trial power p1 is the smallest power with 2^p1 ≥ s, but at least MINP. The trial base is b rounded down to 2^p1, and the trial end is b+s rounded up to 2^p1. The final power p is the smallest power covering trial end − trial base, again at least MINP. The reported base is the trial base rounded down to 2^p.
- R5: Each used descriptor reports a size code equal to p − 1 and has its enable output set. An unused second descriptor has its enable output low.
- R6: The slice disable field is 8 bits. Bit i (i = 0 for the lowest-addressed slice) is 0 exactly when slice [base + i·2^(p−3), base + (i+1)·2^(p−3)) overlaps the range.
- R7: When b+s − base exceeds 2^p, the range is cut at base + 2^p. Descriptor 0 takes the part below the cut at index `idx_i`, and descriptor 1 takes the rest at index `idx_i`+1 (modulo 2^IW). Each part is fitted again by R4. `nreg_o` is then 2; otherwise it is 1.
- R8: On success, `next_idx_o` equals `idx_i` + `nreg_o`, modulo 2^IW.
- R9: Requests strobed on consecutive cycles each complete in order, each two cycles after its own strobe, with nothing lost.
- R10: While reset is asserted and after its release, `done_o` and `err_o` are low and `nreg_o` is 0 until the first request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| begin_i | input | AW | First byte address of the range |
| size_i | input | AW | Range length in bytes |
| idx_i | input | IW | First slot index to use |
| done_o | output | 1 | Results valid pulse |
| err_o | output | 1 | Request rejected |
| nreg_o | output | 2 | Number of descriptors produced |
| next_idx_o | output | IW | First slot after those used |
| r0_idx_o | output | IW | Descriptor 0 slot index |
| r0_base_o | output | AW | Descriptor 0 base address |
| r0_code_o | output | PW | Descriptor 0 size code (power − 1) |
| r0_dis_o | output | 8 | Descriptor 0 slice disable field |
| r0_en_o | output | 1 | Descriptor 0 enable |
| r1_idx_o | output | IW | Descriptor 1 slot index |
| r1_base_o | output | AW | Descriptor 1 base address |
| r1_code_o | output | PW | Descriptor 1 size code |
| r1_dis_o | output | 8 | Descriptor 1 slice disable field |
| r1_en_o | output | 1 | Descriptor 1 enable |

## Verification
Two requests can be in flight at once: a new request can be fitted in the first stage while the previous one is split and masked in the second stage. The bench provokes this with bursts of strobes on back-to-back cycles. The bursts mix split, unsplit and rejected requests, so an error result can sit right next to a two-region result. A behavioural model queues one expected result per strobe, tagged with its due cycle. Every clock, the outputs are compared against the head of the queue, or against an idle `done_o` when nothing is due. Any overlap between the stages then shows up as a wrong field or a misplaced pulse.

// File: rtl/region_fitter.sv
module region_fitter #(
  parameter int AW   = 32,
  parameter int IW   = 8,
  parameter int MINP = 5,
  localparam int PW  = $clog2(AW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] begin_i,
  input  logic [AW-1:0] size_i,
  input  logic [IW-1:0] idx_i,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    nreg_o,
  output logic [IW-1:0] next_idx_o,
  output logic [IW-1:0] r0_idx_o,
  output logic [AW-1:0] r0_base_o,
  output logic [PW-1:0] r0_code_o,
  output logic [7:0]    r0_dis_o,
  output logic          r0_en_o,
  output logic [IW-1:0] r1_idx_o,
  output logic [AW-1:0] r1_base_o,
  output logic [PW-1:0] r1_code_o,
  output logic [7:0]    r1_dis_o,
  output logic          r1_en_o
);
  localparam int W = AW + 1;
  localparam logic [W-1:0] TOP = W'(1) << AW;

  function automatic logic [PW-1:0] pceil(input logic [W-1:0] x);
    logic [W-1:0] xm;
    pceil = PW'(MINP);
    xm = x - W'(1);
    for (int i = 0; i < W; i++)
      if (xm[i] && (i + 1) > MINP) pceil = PW'(i + 1);
  endfunction

  function automatic logic [W-1:0] lowm(input logic [PW-1:0] p);
    lowm = (W'(1) << p) - W'(1);
  endfunction

  function automatic logic [W-1:0] up2(input logic [W-1:0] x, input logic [PW-1:0] p);
    up2 = (x + lowm(p)) & ~lowm(p);
  endfunction

  function automatic void fit(input logic [W-1:0] b, input logic [W-1:0] s,
                              output logic [W-1:0] rb, output logic [PW-1:0] rp);
    logic [PW-1:0] p1;
    logic [W-1:0] b2, e2;
    p1 = pceil(s);
    b2 = b & ~lowm(p1);
    e2 = up2(b + s, p1);
    rp = pceil(e2 - b2);
    rb = b2 & ~lowm(rp);
  endfunction

  function automatic logic [7:0] dmask(input logic [W-1:0] b, input logic [W-1:0] e,
                                       input logic [W-1:0] rb, input logic [PW-1:0] p);
    logic [PW-1:0] sh;
    logic [W-1:0] u, v;
    logic [7:0] en;
    sh = p - PW'(3);
    u = (b - rb) >> sh;
    v = (up2(e, sh) - rb) >> sh;
    for (int i = 0; i < 8; i++) en[i] = (W'(i) >= u) && (W'(i) < v);
    dmask = ~en;
  endfunction

  logic [W-1:0] bx, sx, ex, fa_rb;
  logic [PW-1:0] fa_rp;
  logic bad, split;

  assign bx    = {1'b0, begin_i};
  assign sx    = {1'b0, size_i};
  assign ex    = bx + sx;
  assign bad   = (sx == '0) || (ex > TOP);
  always_comb fit(bx, sx, fa_rb, fa_rp);
  assign split = (ex - fa_rb) > (W'(1) << fa_rp);

  logic a_vld, a_err, a_split;
  logic [W-1:0] a_b, a_e, a_rb;
  logic [PW-1:0] a_rp;
  logic [IW-1:0] a_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0; a_err <= 1'b0; a_split <= 1'b0;
      a_b <= '0; a_e <= '0; a_rb <= '0; a_rp <= '0; a_idx <= '0;
    end else begin
      a_vld <= start_i;
      if (start_i) begin
        a_err <= bad; a_split <= split;
        a_b <= bx; a_e <= ex; a_rb <= fa_rb; a_rp <= fa_rp; a_idx <= idx_i;
      end
    end
  end

  logic [W-1:0] re, c1_rb, c2_rb, q0_rb;
  logic [PW-1:0] c1_rp, c2_rp, q0_rp;
  logic [7:0] q0_dis, q1_dis;

  assign re = a_rb + (W'(1) << a_rp);
  always_comb begin
    fit(a_b, re - a_b, c1_rb, c1_rp);
    fit(re, a_e - re, c2_rb, c2_rp);
  end
  assign q0_rb  = a_split ? c1_rb : a_rb;
  assign q0_rp  = a_split ? c1_rp : a_rp;
  assign q0_dis = dmask(a_b, a_split ? re : a_e, q0_rb, q0_rp);
  assign q1_dis = dmask(re, a_e, c2_rb, c2_rp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0; err_o <= 1'b0; nreg_o <= '0; next_idx_o <= '0;
      r0_idx_o <= '0; r0_base_o <= '0; r0_code_o <= '0; r0_dis_o <= '0; r0_en_o <= 1'b0;
      r1_idx_o <= '0; r1_base_o <= '0; r1_code_o <= '0; r1_dis_o <= '0; r1_en_o <= 1'b0;
    end else begin
      done_o <= a_vld;
      if (a_vld) begin
        err_o      <= a_err;
        nreg_o     <= a_err ? 2'd0 : (a_split ? 2'd2 : 2'd1);
        next_idx_o <= a_err ? a_idx : a_idx + (a_split ? IW'(2) : IW'(1));
        r0_idx_o   <= a_err ? '0 : a_idx;
        r0_base_o  <= a_err ? '0 : q0_rb[AW-1:0];
        r0_code_o  <= a_err ? '0 : q0_rp - PW'(1);
        r0_dis_o   <= a_err ? '0 : q0_dis;
        r0_en_o    <= !a_err;
        r1_idx_o   <= (a_err || !a_split) ? '0 : a_idx + IW'(1);
        r1_base_o  <= (a_err || !a_split) ? '0 : c2_rb[AW-1:0];
        r1_code_o  <= (a_err || !a_split) ? '0 : c2_rp - PW'(1);
        r1_dis_o   <= (a_err || !a_split) ? '0 : q1_dis;
        r1_en_o    <= !a_err && a_split;
      end
    end
  end
endmodule

// File: rtl/region_fitter_chk.sv
module region_fitter_chk #(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          done_o,
  input logic          err_o,
  input logic [1:0]    nreg_o,
  input logic [IW-1:0] next_idx_o,
  input logic [IW-1:0] r0_idx_o,
  input logic [AW-1:0] r0_base_o,
  input logic [PW-1:0] r0_code_o,
  input logic [7:0]    r0_dis_o,
  input logic          r0_en_o,
  input logic [IW-1:0] r1_idx_o,
  input logic          r1_en_o
);
  logic [AW:0] lim0;
  assign lim0 = ((AW + 1)'(1) << (r0_code_o + PW'(1))) - (AW + 1)'(1);

  a_r1_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##2 done_o);
  a_r2_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && done_o |-> nreg_o == 2'd0 && !r0_en_o && !r1_en_o);
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> ({1'b0, r0_base_o} & lim0) == '0);
  a_r5_enables: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> r0_en_o && (r1_en_o == (nreg_o == 2'd2)));
  a_r6_some_slice: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> r0_dis_o != 8'hFF);
  a_r7_second_idx: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && nreg_o == 2'd2 |-> r1_idx_o == r0_idx_o + IW'(1));
  a_r8_next_idx: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> next_idx_o == r0_idx_o + IW'(nreg_o));
endmodule

bind region_fitter region_fitter_chk #(.AW(AW), .IW(IW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
  .nreg_o(nreg_o), .next_idx_o(next_idx_o), .r0_idx_o(r0_idx_o),
  .r0_base_o(r0_base_o), .r0_code_o(r0_code_o), .r0_dis_o(r0_dis_o),
  .r0_en_o(r0_en_o), .r1_idx_o(r1_idx_o), .r1_en_o(r1_en_o)
);

// File: tb/region_fitter_bench.sv
`timescale 1ns/1ps
module region_fitter_bench;
  localparam int AW = 32, IW = 8, PW = 6, MINP = 5;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [AW-1:0] begin_i = '0, size_i = '0;
  logic [IW-1:0] idx_i = '0;
  logic done_o, err_o, r0_en_o, r1_en_o;
  logic [1:0] nreg_o;
  logic [IW-1:0] next_idx_o, r0_idx_o, r1_idx_o;
  logic [AW-1:0] r0_base_o, r1_base_o;
  logic [PW-1:0] r0_code_o, r1_code_o;
  logic [7:0] r0_dis_o, r1_dis_o;

  always #2.5 clk = ~clk;

  region_fitter #(.AW(AW), .IW(IW), .MINP(MINP)) u_region_fitter (.*);

  typedef struct {
    longint due; bit err; int n; longint nxt;
    longint i0, b0, c0, m0, i1, b1, c1, m1;
  } exp_t;

  exp_t q[$];
  longint cyc = 0;
  int tests = 0, fails = 0;
  bit burst = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int lceil(longint x);
    int p = 0;
    while ((64'sd1 <<< p) < x) p++;
    return (p < MINP) ? MINP : p;
  endfunction

  function automatic void lfit(longint b, longint s, output longint rb, output int p);
    int p1;
    longint g1, b2, e2, g;
    p1 = lceil(s);
    g1 = 64'sd1 <<< p1;
    b2 = b - (b % g1);
    e2 = ((b + s + g1 - 1) / g1) * g1;
    p = lceil(e2 - b2);
    g = 64'sd1 <<< p;
    rb = b2 - (b2 % g);
  endfunction

  function automatic longint lmask(longint b, longint e, longint rb, int p);
    longint g = 64'sd1 <<< (p - 3);
    longint m = 8'hFF;
    for (int i = 0; i < 8; i++)
      if (rb + i * g < e && rb + (i + 1) * g > b) m &= ~(64'sd1 <<< i);
    return m;
  endfunction

  function automatic exp_t model(longint b, longint s, longint idx);
    exp_t x;
    longint rb, re, e;
    int p;
    x = '{default: 0};
    e = b + s;
    if (s == 0 || e > (64'sd1 <<< AW)) begin
      x.err = 1; x.nxt = idx; return x;
    end
    lfit(b, s, rb, p);
    x.i0 = idx;
    if (e - rb > (64'sd1 <<< p)) begin
      re = rb + (64'sd1 <<< p);
      lfit(b, re - b, x.b0, p);
      x.c0 = p - 1; x.m0 = lmask(b, re, x.b0, p);
      lfit(re, e - re, x.b1, p);
      x.c1 = p - 1; x.m1 = lmask(re, e, x.b1, p);
      x.i1 = (idx + 1) % 256; x.n = 2;
    end else begin
      x.b0 = rb; x.c0 = p - 1; x.m0 = lmask(b, e, rb, p); x.n = 1;
    end
    x.nxt = (idx + x.n) % 256;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (start_i) begin
      exp_t x;
      x = model(longint'(begin_i), longint'(size_i), longint'(idx_i));
      x.due = cyc + 2;
      q.push_back(x);
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t x;
        string t;
        x = q.pop_front();
        t = burst ? "R1,R9 done" : "R1 done";
        chk(done_o == 1'b1, t, done_o, 1);
        chk(err_o == x.err, "R2,R3 err", err_o, x.err);
        chk(nreg_o == x.n, "R7 nreg", nreg_o, x.n);
        chk(next_idx_o == x.nxt, "R8 next_idx", next_idx_o, x.nxt);
        chk(r0_idx_o == x.i0, "R7 r0_idx", r0_idx_o, x.i0);
        chk(r0_base_o == x.b0, "R4 r0_base", r0_base_o, x.b0);
        chk(r0_code_o == x.c0, "R5 r0_code", r0_code_o, x.c0);
        chk(r0_dis_o == x.m0, "R6 r0_dis", r0_dis_o, x.m0);
        chk(r0_en_o == (x.n != 0), "R5 r0_en", r0_en_o, x.n != 0);
        chk(r1_idx_o == x.i1, "R7 r1_idx", r1_idx_o, x.i1);
        chk(r1_base_o == x.b1, "R7 r1_base", r1_base_o, x.b1);
        chk(r1_code_o == x.c1, "R7 r1_code", r1_code_o, x.c1);
        chk(r1_dis_o == x.m1, "R7 r1_dis", r1_dis_o, x.m1);
        chk(r1_en_o == (x.n == 2), "R5 r1_en", r1_en_o, x.n == 2);
      end else begin
        chk(done_o == 1'b0, "R1 idle", done_o, 0);
      end
    end
  end

  task automatic put(longint b, longint s, longint idx);
    begin_i = AW'(b); size_i = AW'(s); idx_i = IW'(idx); start_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic one(longint b, longint s, longint idx);
    put(b, s, idx);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o == 0 && err_o == 0 && nreg_o == 0, "R10 reset", {done_o, err_o, nreg_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 0 && err_o == 0 && nreg_o == 0, "R10 after release", {done_o, err_o, nreg_o}, 0);
    one(32'h1000, 32'h1000, 3);        // R4 exact fit, all slices on
    one(32'h1000, 32'hC00, 4);         // R6 top two slices off
    one(32'h0F00, 32'h200, 10);        // R7 split at 0x1000
    one(32'h0100, 4, 1);               // R4 clamp to minimum power
    one(32'h2000, 0, 7);               // R2 zero size
    one(32'hFFFF_FF00, 32'h100, 0);    // R3 ends exactly at top
    one(32'hFFFF_FF00, 32'h101, 0);    // R3 runs past top
    one(0, 32'h8000_0001, 2);          // R4 full address space region
    one(32'h0F00, 32'h200, 255);       // R8 index wraps with split
    burst = 1;                          // R9 back-to-back strobes
    put(32'h0F00, 32'h200, 20);
    put(32'h4000, 0, 21);
    put(32'h1000, 32'hC00, 22);
    put(32'h0FC0, 32'h80, 23);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 400; k++) begin
      longint b = longint'($urandom & 32'h7FFF_FFFF);
      longint s = longint'($urandom % 20000);
      if (k % 3 == 0) one(b, s, k % 256);
      else put(b, s, k % 256);
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule